// File: doc/BRIEF.md
# Zone Plate Pattern Generator

This block turns a stream of pixel coordinates into a circular zone plate test image. Each coordinate is measured against a programmable centre point; the squared radius is scaled by an 8.8 fixed-point gain and then divided by a power of two chosen by a coarse shift. Along the radius the resulting phase folds into a triangle wave, so concentric rings run from black to full scale and back again.

The block sits downstream of a raster counter that produces `coord_x`/`coord_y` with a strobe. One sample comes back per strobed coordinate after a constant number of cycles. In RGB use the luminance value goes on every channel. In YCbCr use channel 0 carries luma and the chroma channels hold mid-grey. All control inputs are captured together with the coordinate they belong to, so settings may change between any two pixels.

Top module: `zp_gen`

## Requirements
- R1: `pix_valid` equals `coord_valid` delayed by exactly 5 clock cycles, and each output sample belongs to the coordinate presented 5 cycles earlier.
- R2: The distances dx = x − origin_x and dy = y − origin_y are signed, so two points mirrored about the origin in x or in y give the same sample.
- R3: With c the effective coarse shift and f = `fine_gain`, phase = ((dx² + dy²) · f) >> (c + 8). The luma is bits [SAMPLE_W−1:0] of the phase when phase bit SAMPLE_W is 0, and the bitwise inverse of those bits when it is 1.
- R4: A `coarse_shift` value of 0 is taken as 1. Values 1 to 31 are used as given.
- R5: The pixel at the origin itself always has luma 0.
- R6: A `fine_gain` of 0 gives luma 0 at every coordinate.
- R7: With `ycc_mode` = 0, every channel of `pix_data` carries the luma value. Channel k occupies bits [k·SAMPLE_W +: SAMPLE_W].
- R8: With `ycc_mode` = 1, channel 0 carries the luma value and every other channel carries 2^(SAMPLE_W−1).
- R9: Whenever `pix_valid` is 0, `pix_data` is all zeros.
- R10: While `rst_n` is low, `pix_valid` is 0 and `pix_data` is 0.
- R11: The origin, `coarse_shift`, `fine_gain` and `ycc_mode` are captured with each coordinate. A change in one cycle affects only the coordinates presented from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coord_valid | input | 1 | Coordinate strobe |
| coord_x | input | COORD_W | Pixel column |
| coord_y | input | COORD_W | Pixel row |
| origin_x | input | COORD_W | Ring centre column |
| origin_y | input | COORD_W | Ring centre row |
| coarse_shift | input | 5 | Coarse exponent; 0 is taken as 1 |
| fine_gain | input | 16 | Unsigned 8.8 gain on the squared radius |
| ycc_mode | input | 1 | 1: mid-grey chroma; 0: luma on all channels |
| pix_valid | output | 1 | Output sample strobe |
| pix_data | output | NUM_CHAN*SAMPLE_W | Packed channels, channel 0 in the low bits |

## Verification
A wrong delta, square or product register corrupts the luma of the one coordinate that is in that stage. The error shows up exactly five cycles after that coordinate enters, as a mismatch against the bench's arithmetic model. A control field that is sampled in the wrong stage only shows when the control changes between neighbouring pixels, so the stimulus changes the gain, shift, origin and mode on every cycle. A broken valid shift register or output mask appears at once as a strobe off by a cycle, or as non-zero data on an idle cycle.

// File: rtl/zp_pkg.sv
package zp_pkg;

   localparam int ZP_FINE_W   = 16;
   localparam int ZP_COARSE_W = 5;
   localparam int ZP_FRAC_W   = 8;
   localparam int ZP_SHIFT_W  = 6;
   localparam int ZP_LATENCY  = 5;

   typedef struct packed {
      logic [ZP_COARSE_W-1:0] coarse;
      logic [ZP_FINE_W-1:0]   fine;
      logic                   ycc;
   } zp_ctrl_t;

   function automatic logic [ZP_SHIFT_W-1:0] zp_shift_amount(input logic [ZP_COARSE_W-1:0] c);
      logic [ZP_COARSE_W-1:0] eff;
      eff = (c == '0) ? ZP_COARSE_W'(1) : c;
      return ZP_SHIFT_W'(eff) + ZP_SHIFT_W'(ZP_FRAC_W);
   endfunction

endpackage

// File: rtl/zp_delta.sv
module zp_delta
   import zp_pkg::*;
#(
   parameter int COORD_W = 14
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  zp_ctrl_t                  in_ctrl,
   input  logic [COORD_W-1:0]        pos_x,
   input  logic [COORD_W-1:0]        pos_y,
   input  logic [COORD_W-1:0]        org_x,
   input  logic [COORD_W-1:0]        org_y,
   output logic                      out_valid,
   output zp_ctrl_t                  out_ctrl,
   output logic signed [COORD_W:0]   dist_x,
   output logic signed [COORD_W:0]   dist_y
);

   localparam int AXES = 2;

   logic [COORD_W-1:0]      pos_a [AXES];
   logic [COORD_W-1:0]      org_a [AXES];
   logic signed [COORD_W:0] dist_q [AXES];

   always_comb begin
      pos_a[0] = pos_x;
      pos_a[1] = pos_y;
      org_a[0] = org_x;
      org_a[1] = org_y;
   end

   for (genvar a = 0; a < AXES; a++) begin : g_axis
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dist_q[a] <= '0;
         end else begin
            dist_q[a] <= $signed({1'b0, pos_a[a]}) - $signed({1'b0, org_a[a]});
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_ctrl  <= '0;
      end else begin
         out_valid <= in_valid;
         out_ctrl  <= in_ctrl;
      end
   end

   assign dist_x = dist_q[0];
   assign dist_y = dist_q[1];

endmodule

// File: rtl/zp_energy.sv
module zp_energy
   import zp_pkg::*;
#(
   parameter int COORD_W = 14,
   localparam int SQ_W   = 2 * COORD_W + 1,
   localparam int PROD_W = SQ_W + ZP_FINE_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  zp_ctrl_t                in_ctrl,
   input  logic signed [COORD_W:0] dist_x,
   input  logic signed [COORD_W:0] dist_y,
   output logic                    out_valid,
   output zp_ctrl_t                out_ctrl,
   output logic [PROD_W-1:0]       energy
);

   logic [COORD_W:0]   neg_x, neg_y;
   logic [COORD_W-1:0] mag_x, mag_y;
   logic [SQ_W-1:0]    sq_sum;
   logic [SQ_W-1:0]    sq_q;
   logic               mid_valid;
   zp_ctrl_t           mid_ctrl;

   always_comb begin
      neg_x  = -dist_x;
      neg_y  = -dist_y;
      mag_x  = dist_x[COORD_W] ? neg_x[COORD_W-1:0] : dist_x[COORD_W-1:0];
      mag_y  = dist_y[COORD_W] ? neg_y[COORD_W-1:0] : dist_y[COORD_W-1:0];
      sq_sum = SQ_W'(mag_x) * SQ_W'(mag_x) + SQ_W'(mag_y) * SQ_W'(mag_y);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sq_q      <= '0;
         mid_valid <= 1'b0;
         mid_ctrl  <= '0;
      end else begin
         sq_q      <= sq_sum;
         mid_valid <= in_valid;
         mid_ctrl  <= in_ctrl;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         energy    <= '0;
         out_valid <= 1'b0;
         out_ctrl  <= '0;
      end else begin
         energy    <= PROD_W'(sq_q) * PROD_W'(mid_ctrl.fine);
         out_valid <= mid_valid;
         out_ctrl  <= mid_ctrl;
      end
   end

endmodule

// File: rtl/zp_wave.sv
module zp_wave
   import zp_pkg::*;
#(
   parameter int SAMPLE_W = 10,
   parameter int PROD_W   = 45
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  zp_ctrl_t            in_ctrl,
   input  logic [PROD_W-1:0]   energy,
   output logic                out_valid,
   output zp_ctrl_t            out_ctrl,
   output logic [SAMPLE_W-1:0] luma
);

   logic [ZP_SHIFT_W-1:0] shamt;
   logic [PROD_W-1:0]     phase;
   logic [SAMPLE_W-1:0]   ramp;
   logic [SAMPLE_W-1:0]   tri_val;

   always_comb begin
      shamt   = zp_shift_amount(in_ctrl.coarse);
      phase   = energy >> shamt;
      ramp    = phase[SAMPLE_W-1:0];
      tri_val = phase[SAMPLE_W] ? ~ramp : ramp;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         luma      <= '0;
         out_valid <= 1'b0;
         out_ctrl  <= '0;
      end else begin
         luma      <= tri_val;
         out_valid <= in_valid;
         out_ctrl  <= in_ctrl;
      end
   end

endmodule

// File: rtl/zp_gen.sv
module zp_gen
   import zp_pkg::*;
#(
   parameter int SAMPLE_W = 10,
   parameter int NUM_CHAN = 3,
   parameter int COORD_W  = 14,
   localparam int SQ_W    = 2 * COORD_W + 1,
   localparam int PROD_W  = SQ_W + ZP_FINE_W,
   localparam int DATA_W  = NUM_CHAN * SAMPLE_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   coord_valid,
   input  logic [COORD_W-1:0]     coord_x,
   input  logic [COORD_W-1:0]     coord_y,
   input  logic [COORD_W-1:0]     origin_x,
   input  logic [COORD_W-1:0]     origin_y,
   input  logic [ZP_COARSE_W-1:0] coarse_shift,
   input  logic [ZP_FINE_W-1:0]   fine_gain,
   input  logic                   ycc_mode,
   output logic                   pix_valid,
   output logic [DATA_W-1:0]      pix_data
);

   initial begin
      assert (SAMPLE_W >= 8 && SAMPLE_W <= 16)
         else $error("zp_gen: SAMPLE_W must be 8..16");
      assert (NUM_CHAN >= 1 && NUM_CHAN <= 4)
         else $error("zp_gen: NUM_CHAN must be 1..4");
      assert (COORD_W >= 2 && COORD_W <= 14)
         else $error("zp_gen: COORD_W must be 2..14");
   end

   localparam logic [SAMPLE_W-1:0] MID_GREY = SAMPLE_W'(1) << (SAMPLE_W - 1);

   zp_ctrl_t in_ctrl;
   assign in_ctrl = '{coarse: coarse_shift, fine: fine_gain, ycc: ycc_mode};

   logic                    s1_valid, s3_valid, s4_valid;
   zp_ctrl_t                s1_ctrl, s3_ctrl, s4_ctrl;
   logic signed [COORD_W:0] s1_dx, s1_dy;
   logic [PROD_W-1:0]       s3_energy;
   logic [SAMPLE_W-1:0]     s4_luma;

   zp_delta #(.COORD_W(COORD_W)) u_delta (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (coord_valid),
      .in_ctrl   (in_ctrl),
      .pos_x     (coord_x),
      .pos_y     (coord_y),
      .org_x     (origin_x),
      .org_y     (origin_y),
      .out_valid (s1_valid),
      .out_ctrl  (s1_ctrl),
      .dist_x    (s1_dx),
      .dist_y    (s1_dy)
   );

   zp_energy #(.COORD_W(COORD_W)) u_energy (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (s1_valid),
      .in_ctrl   (s1_ctrl),
      .dist_x    (s1_dx),
      .dist_y    (s1_dy),
      .out_valid (s3_valid),
      .out_ctrl  (s3_ctrl),
      .energy    (s3_energy)
   );

   zp_wave #(.SAMPLE_W(SAMPLE_W), .PROD_W(PROD_W)) u_wave (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (s3_valid),
      .in_ctrl   (s3_ctrl),
      .energy    (s3_energy),
      .out_valid (s4_valid),
      .out_ctrl  (s4_ctrl),
      .luma      (s4_luma)
   );

   logic [DATA_W-1:0] mapped;

   assign mapped[SAMPLE_W-1:0] = s4_luma;

   if (NUM_CHAN > 1) begin : g_chroma
      for (genvar k = 1; k < NUM_CHAN; k++) begin : g_chan
         assign mapped[k*SAMPLE_W +: SAMPLE_W] = s4_ctrl.ycc ? MID_GREY : s4_luma;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_valid <= 1'b0;
         pix_data  <= '0;
      end else begin
         pix_valid <= s4_valid;
         pix_data  <= s4_valid ? mapped : '0;
      end
   end

endmodule

// File: rtl/zp_gen_chk.sv
module zp_gen_chk #(
   parameter int SAMPLE_W = 10,
   parameter int NUM_CHAN = 3,
   parameter int COORD_W  = 14
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         coord_valid,
   input logic [COORD_W-1:0]           coord_x,
   input logic [COORD_W-1:0]           coord_y,
   input logic [COORD_W-1:0]           origin_x,
   input logic [COORD_W-1:0]           origin_y,
   input logic                         ycc_mode,
   input logic                         pix_valid,
   input logic [NUM_CHAN*SAMPLE_W-1:0] pix_data
);

   logic [2:0] warm_q;
   logic       all_luma;
   logic       all_mid;
   logic       at_origin;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           warm_q <= '0;
      else if (warm_q != 7) warm_q <= warm_q + 3'd1;
   end

   assign at_origin = (coord_x == origin_x) && (coord_y == origin_y);

   always_comb begin
      all_luma = 1'b1;
      all_mid  = 1'b1;
      for (int k = 1; k < NUM_CHAN; k++) begin
         if (pix_data[k*SAMPLE_W +: SAMPLE_W] != pix_data[SAMPLE_W-1:0]) all_luma = 1'b0;
         if (pix_data[k*SAMPLE_W +: SAMPLE_W] != SAMPLE_W'(1) << (SAMPLE_W - 1)) all_mid = 1'b0;
      end
   end

   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q >= 5) |-> (pix_valid == $past(coord_valid, 5)));

   p_origin_black_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q >= 5 && pix_valid && $past(at_origin, 5)) |-> (pix_data[SAMPLE_W-1:0] == '0));

   p_rgb_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q >= 5 && pix_valid && !$past(ycc_mode, 5)) |-> all_luma);

   p_ycc_mid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q >= 5 && pix_valid && $past(ycc_mode, 5)) |-> all_mid);

   p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |-> (pix_data == '0));

endmodule

bind zp_gen zp_gen_chk #(
   .SAMPLE_W (SAMPLE_W),
   .NUM_CHAN (NUM_CHAN),
   .COORD_W  (COORD_W)
) u_zp_gen_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .coord_valid (coord_valid),
   .coord_x     (coord_x),
   .coord_y     (coord_y),
   .origin_x    (origin_x),
   .origin_y    (origin_y),
   .ycc_mode    (ycc_mode),
   .pix_valid   (pix_valid),
   .pix_data    (pix_data)
);

// File: tb/test_zp_gen.sv
module test_zp_gen;

   localparam int SW    = 10;
   localparam int NCH   = 3;
   localparam int CW    = 14;
   localparam int DW    = NCH * SW;
   localparam int RING  = 8;
   localparam int LIMIT = 100000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          coord_valid = 1'b0;
   logic [CW-1:0] coord_x = '0, coord_y = '0, origin_x = '0, origin_y = '0;
   logic [4:0]    coarse_shift = '0;
   logic [15:0]   fine_gain = '0;
   logic          ycc_mode = 1'b0;
   logic          pix_valid;
   logic [DW-1:0] pix_data;

   int n_checks = 0;
   int n_fail   = 0;
   int step_n   = 0;
   bit done     = 1'b0;

   logic          ring_v   [RING];
   logic [DW-1:0] ring_d   [RING];
   string         ring_tag [RING];

   always #2.5 clk = ~clk;

   zp_gen #(.SAMPLE_W(SW), .NUM_CHAN(NCH), .COORD_W(CW)) i_zp_gen (
      .clk          (clk),
      .rst_n        (rst_n),
      .coord_valid  (coord_valid),
      .coord_x      (coord_x),
      .coord_y      (coord_y),
      .origin_x     (origin_x),
      .origin_y     (origin_y),
      .coarse_shift (coarse_shift),
      .fine_gain    (fine_gain),
      .ycc_mode     (ycc_mode),
      .pix_valid    (pix_valid),
      .pix_data     (pix_data)
   );

   function automatic logic [SW-1:0] model_luma(int x, int y, int ox, int oy, int c, int f);
      longint dx, dy, ph, low, msk;
      int     cc;
      dx  = longint'(x) - longint'(ox);
      dy  = longint'(y) - longint'(oy);
      cc  = (c == 0) ? 1 : c;
      ph  = ((dx * dx + dy * dy) * longint'(f)) >>> (cc + 8);
      msk = (longint'(1) << SW) - 1;
      low = ph & msk;
      if (((ph >>> SW) & 1) == 1) low = msk - low;
      return SW'(low);
   endfunction

   function automatic logic [DW-1:0] model_word(logic v, int x, int y, int ox, int oy,
                                                 int c, int f, logic m);
      logic [DW-1:0] w;
      logic [SW-1:0] l;
      w = '0;
      if (v) begin
         l = model_luma(x, y, ox, oy, c, f);
         for (int k = 0; k < NCH; k++)
            w[k*SW +: SW] = (k != 0 && m) ? SW'(1) << (SW - 1) : l;
      end
      return w;
   endfunction

   task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(logic v, int x, int y, int ox, int oy, int c, int f, logic m, string tag);
      int slot;
      coord_valid  = v;
      coord_x      = CW'(x);
      coord_y      = CW'(y);
      origin_x     = CW'(ox);
      origin_y     = CW'(oy);
      coarse_shift = 5'(c);
      fine_gain    = 16'(f);
      ycc_mode     = m;
      slot = step_n % RING;
      ring_v[slot]   = v;
      ring_d[slot]   = model_word(v, x, y, ox, oy, c, f, m);
      ring_tag[slot] = v ? tag : "R9 idle";
      @(posedge clk);
      @(negedge clk);
      if (step_n >= 4) begin
         slot = (step_n - 4) % RING;
         check({"R1 valid / ", ring_tag[slot]}, DW'(pix_valid), DW'(ring_v[slot]));
         check(ring_tag[slot], pix_data, ring_d[slot]);
      end
      step_n++;
   endtask

   initial begin
      #(LIMIT * 5);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h2F1A_55C3));
      repeat (3) @(negedge clk);
      // R10: outputs quiet while reset is held
      check("R10 reset valid", DW'(pix_valid), '0);
      check("R10 reset data", pix_data, '0);
      rst_n = 1'b1;

      // R3 / R7 directed: ring values off axis in RGB
      step(1, 100, 40, 64, 64, 1, 256, 0, "R3 R7 rgb");
      step(1, 16383, 16383, 0, 0, 1, 65535, 0, "R3 max corner");
      // R5: origin is black even with large gain
      step(1, 500, 700, 500, 700, 1, 65535, 0, "R5 origin");
      // R2: mirrored pair about the origin
      step(1, 1000 + 37, 800, 1000, 800, 3, 1000, 0, "R2 plus x");
      step(1, 1000 - 37, 800, 1000, 800, 3, 1000, 0, "R2 minus x");
      step(1, 1000, 800 - 91, 1000, 800, 3, 1000, 1, "R2 minus y");
      step(1, 1000, 800 + 91, 1000, 800, 3, 1000, 1, "R2 plus y");
      // R4: coarse 0 behaves as 1
      step(1, 300, 20, 0, 0, 0, 777, 0, "R4 coarse zero");
      step(1, 300, 20, 0, 0, 1, 777, 0, "R4 coarse one");
      // R6: zero gain gives black
      step(1, 9000, 12, 3, 4000, 17, 0, 0, "R6 zero gain");
      // R8: chroma mid-grey
      step(1, 55, 66, 0, 0, 2, 4096, 1, "R8 ycc");
      // R9: idle gap
      step(0, 1, 2, 3, 4, 5, 6, 0, "R9 idle");
      // R11: controls change every cycle
      for (int i = 0; i < 12; i++)
         step(1, 200 + i, 200, 180, 190 + i, 1 + (i % 4), 300 * (i + 1), logic'(i % 2), "R11 per-pixel ctrl");

      // R3 random mix, some near the origin
      for (int i = 0; i < 3000; i++) begin
         int ox, oy, x, y;
         ox = $urandom_range(0, 16383);
         oy = $urandom_range(0, 16383);
         if ($urandom_range(0, 3) == 0) begin
            x = ox + $urandom_range(0, 64) - 32;
            y = oy + $urandom_range(0, 64) - 32;
            if (x < 0) x = 0;
            if (y < 0) y = 0;
            if (x > 16383) x = 16383;
            if (y > 16383) y = 16383;
         end else begin
            x = $urandom_range(0, 16383);
            y = $urandom_range(0, 16383);
         end
         step(logic'($urandom_range(0, 4) != 0), x, y, ox, oy, $urandom_range(0, 31),
              $urandom_range(0, 65535), logic'($urandom_range(0, 1)), "R3 random");
      end

      repeat (5) step(0, 0, 0, 0, 0, 1, 1, 0, "R9 flush");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule